// File: doc/BRIEF.md
# Type B Tag Response Framer

This block turns a response held in a small byte buffer into the serial symbol stream that a contactless Type B tag sends back to a reader. The stream goes to a BPSK load modulator. One symbol is one bit period, and each symbol gives the logic level that the modulator should present for that period. The payload already carries its CRC; the block only adds the framing around it. Subcarrier generation and analog modulation happen downstream.

To send a frame, software writes the payload bytes through a byte write port and places the byte count on `frame_len`. It then pulses `start`. The block emits the frame in this order:

- a long run of ones, so the reader can settle its phase reference;
- a start marker, made of a low stretch followed by a short high stretch;
- every byte as a ten-bit character;
- an end marker with the same shape as the start marker.

A bit-rate enable sets the pace. The block advances by one symbol on each clock where `bit_en` is high, and it flags each new symbol with a one-cycle valid strobe.

Top module: `tbr_framer`

## Requirements
- R1: After reset, `busy` is 0, `sym_valid` is 0 and `sym_out` is 1.
- R2: A `start` pulse while idle, with `frame_len` between 1 and MAX_LEN, raises `busy` on the next clock. The first PRE_BITS (20) symbols emitted are all logic one.
- R3: The start marker follows the preamble. It is MRK_LOW (10) zero symbols and then MRK_HIGH (2) one symbols.
- R4: Each payload byte is emitted as one 0 start symbol, then its eight data bits with bit 0 first and bit 7 last, then one 1 stop symbol. Bytes go out in buffer order, starting at address 0.
- R5: The end marker follows the last byte. It is 10 zero symbols and then 2 one symbols. A frame of N bytes has exactly 44 + 10·N symbols.
- R6: A symbol is emitted (`sym_valid` high for one cycle, with `sym_out` holding its value) only in the cycle after a clock edge where `bit_en` and `busy` were both high. Exactly one symbol is emitted for each such edge.
- R7: `busy` falls on the same edge that presents the final end-marker symbol. It is high on every earlier symbol of the frame.
- R8: A `start` pulse while `busy` is high is ignored, even with a different `frame_len`. The frame in flight is emitted unchanged.
- R9: A `start` pulse with `frame_len` equal to 0 or greater than MAX_LEN (32) is ignored. `busy` stays low and no symbol is emitted.
- R10: Whenever `busy` is low, `sym_out` is 1.
- R11: Frames of 1 byte and of MAX_LEN (32) bytes are both framed correctly, back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Payload buffer write strobe |
| wr_addr | input | 5 | Payload byte address (log2 MAX_LEN) |
| wr_data | input | 8 | Payload byte to store |
| frame_len | input | 6 | Payload byte count, 1..MAX_LEN |
| start | input | 1 | Begin a frame (one-cycle pulse) |
| bit_en | input | 1 | Bit-period enable; one symbol per high cycle while busy |
| sym_out | output | 1 | Current symbol level |
| sym_valid | output | 1 | One-cycle strobe marking a new symbol |
| busy | output | 1 | A frame is being emitted |

## Verification
A sequencer counter that is off by one shows up within a single frame, and it shows at the ports. The preamble, a marker or a character comes out one symbol too long or too short. That shifts every later symbol and changes the total count, so a comparison of the whole captured stream against a stream built from the requirements catches it.

A wrong bit-order or character-position decode corrupts the first payload symbol whose value differs. This shows from byte 0, bit 1 onward.

A bad acceptance decode for `start` shows up in two ways. If the block wrongly accepts a start, `busy` rises in the next cycle. If the block wrongly takes a new start mid-frame, the length changes and the count and end marker come out wrong.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

   // Frame sections, in emission order
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_PRE  = 3'd1,
      PH_SOF  = 3'd2,
      PH_DATA = 3'd3,
      PH_EOF  = 3'd4
   } tbr_phase_e;

   // Character layout: start bit, eight data bits, stop bit
   localparam int CHAR_BITS = 10;
   localparam int DATA_BITS = 8;

endpackage

// File: rtl/tbr_buf.sv
module tbr_buf #(
   parameter int MAX_LEN = 32,
   parameter int AW      = 5
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_idx,
   output logic [7:0]    rd_data
);

   logic [7:0] mem_q [MAX_LEN];

   logic addr_in_range;
   assign addr_in_range = ({1'b0, wr_addr} < (AW+1)'(MAX_LEN));

   always_ff @(posedge clk) begin
      if (wr_en && addr_in_range) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/tbr_seq.sv
module tbr_seq
   import tbr_pkg::*;
#(
   parameter int MAX_LEN  = 32,
   parameter int PRE_BITS = 20,
   parameter int MRK_LOW  = 10,
   parameter int MRK_HIGH = 2,
   parameter int LW       = 6,
   parameter int AW       = 5,
   parameter int CW       = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic          step,
   input  logic [LW-1:0] len_q,
   output tbr_phase_e    phase_o,
   output logic [CW-1:0] cnt_o,
   output logic [3:0]    char_pos_o,
   output logic [AW-1:0] byte_idx_o
);

   localparam int MRK_TOT = MRK_LOW + MRK_HIGH;

   tbr_phase_e    phase_q;
   logic [CW-1:0] cnt_q;
   logic [3:0]    pos_q;
   logic [AW-1:0] idx_q;

   logic pre_done, mrk_done, char_done, last_byte;
   assign pre_done  = (cnt_q == CW'(PRE_BITS - 1));
   assign mrk_done  = (cnt_q == CW'(MRK_TOT - 1));
   assign char_done = (pos_q == 4'(CHAR_BITS - 1));
   assign last_byte = ((LW'(idx_q) + LW'(1)) == len_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         pos_q   <= '0;
         idx_q   <= '0;
      end else if (launch) begin
         phase_q <= PH_PRE;
         cnt_q   <= '0;
         pos_q   <= '0;
         idx_q   <= '0;
      end else if (step) begin
         unique case (phase_q)
            PH_PRE: begin
               if (pre_done) begin
                  phase_q <= PH_SOF;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            PH_SOF: begin
               if (mrk_done) begin
                  phase_q <= PH_DATA;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            PH_DATA: begin
               if (char_done) begin
                  pos_q <= '0;
                  if (last_byte) begin
                     phase_q <= PH_EOF;
                  end else begin
                     idx_q <= idx_q + AW'(1);
                  end
               end else begin
                  pos_q <= pos_q + 4'd1;
               end
            end
            PH_EOF: begin
               if (mrk_done) begin
                  phase_q <= PH_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase_o    = phase_q;
   assign cnt_o      = cnt_q;
   assign char_pos_o = pos_q;
   assign byte_idx_o = idx_q;

   // R11: the byte read pointer never passes the latched length
   p_byte_idx_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DATA) |-> (LW'(idx_q) < len_q));

   // R2: the preamble is left only after its full length
   p_pre_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SOF && $past(phase_q) == PH_PRE) |-> ($past(cnt_q) == CW'(PRE_BITS - 1)));

   // R4: a new byte begins only after a complete character
   p_char_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DATA && $past(phase_q) == PH_DATA && idx_q != $past(idx_q))
         |-> ($past(pos_q) == 4'(CHAR_BITS - 1) && pos_q == 4'd0));

endmodule

// File: rtl/tbr_sym.sv
module tbr_sym
   import tbr_pkg::*;
#(
   parameter int MRK_LOW   = 10,
   parameter int CW        = 5,
   parameter bit LSB_FIRST = 1'b1
) (
   input  tbr_phase_e    phase,
   input  logic [CW-1:0] cnt,
   input  logic [3:0]    char_pos,
   input  logic [7:0]    byte_val,
   output logic          sym
);

   logic data_bit;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign data_bit = byte_val[3'(char_pos - 4'd1)];
      end else begin : g_msb
         assign data_bit = byte_val[3'(4'd8 - char_pos)];
      end
   endgenerate

   always_comb begin
      unique case (phase)
         PH_PRE:  sym = 1'b1;
         PH_SOF,
         PH_EOF:  sym = (cnt < CW'(MRK_LOW)) ? 1'b0 : 1'b1;
         PH_DATA: begin
            if (char_pos == 4'd0) begin
               sym = 1'b0;
            end else if (char_pos == 4'(CHAR_BITS - 1)) begin
               sym = 1'b1;
            end else begin
               sym = data_bit;
            end
         end
         default: sym = 1'b1;
      endcase
   end

endmodule

// File: rtl/tbr_framer.sv
module tbr_framer
   import tbr_pkg::*;
#(
   parameter int MAX_LEN   = 32,
   parameter int PRE_BITS  = 20,
   parameter int MRK_LOW   = 10,
   parameter int MRK_HIGH  = 2,
   parameter bit LSB_FIRST = 1'b1,
   localparam int LW       = $clog2(MAX_LEN + 1),
   localparam int AW       = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [LW-1:0] frame_len,
   input  logic          start,
   input  logic          bit_en,
   output logic          sym_out,
   output logic          sym_valid,
   output logic          busy
);

   localparam int MRK_TOT = MRK_LOW + MRK_HIGH;
   localparam int CNT_MAX = (PRE_BITS > MRK_TOT) ? PRE_BITS : MRK_TOT;
   localparam int CW      = $clog2(CNT_MAX + 1);

   generate
      if (MAX_LEN < 1) begin : g_bad_len
         $error("tbr_framer: MAX_LEN must be at least 1");
      end
      if (PRE_BITS < 1 || MRK_LOW < 1 || MRK_HIGH < 1) begin : g_bad_frame
         $error("tbr_framer: preamble and marker lengths must be at least 1");
      end
   endgenerate

   tbr_phase_e    phase;
   logic [CW-1:0] cnt;
   logic [3:0]    char_pos;
   logic [AW-1:0] byte_idx;
   logic [7:0]    byte_val;
   logic [LW-1:0] len_q;
   logic          busy_w, len_ok, launch, step, cur_sym;
   logic          sym_out_q, sym_valid_q;

   assign busy_w = (phase != PH_IDLE);
   assign len_ok = (frame_len != '0) && (frame_len <= LW'(MAX_LEN));
   assign launch = start && !busy_w && len_ok;
   assign step   = busy_w && bit_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= '0;
      end else if (launch) begin
         len_q <= frame_len;
      end
   end

   tbr_buf #(.MAX_LEN(MAX_LEN), .AW(AW)) buf_i (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_idx  (byte_idx),
      .rd_data (byte_val)
   );

   tbr_seq #(
      .MAX_LEN(MAX_LEN), .PRE_BITS(PRE_BITS), .MRK_LOW(MRK_LOW),
      .MRK_HIGH(MRK_HIGH), .LW(LW), .AW(AW), .CW(CW)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .step       (step),
      .len_q      (len_q),
      .phase_o    (phase),
      .cnt_o      (cnt),
      .char_pos_o (char_pos),
      .byte_idx_o (byte_idx)
   );

   tbr_sym #(.MRK_LOW(MRK_LOW), .CW(CW), .LSB_FIRST(LSB_FIRST)) sym_i (
      .phase    (phase),
      .cnt      (cnt),
      .char_pos (char_pos),
      .byte_val (byte_val),
      .sym      (cur_sym)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sym_out_q   <= 1'b1;
         sym_valid_q <= 1'b0;
      end else begin
         sym_valid_q <= step;
         if (step) begin
            sym_out_q <= cur_sym;
         end
      end
   end

   assign sym_out   = sym_out_q;
   assign sym_valid = sym_valid_q;
   assign busy      = busy_w;

   // R6: a symbol only follows an enabled, busy edge
   p_valid_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sym_valid_q |-> ($past(bit_en) && $past(busy_w)));

   // R7: busy drops together with the final (high) end-marker symbol
   p_fall_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_w) |-> (sym_valid_q && sym_out_q));

   // R8: the latched length cannot change mid-frame
   p_len_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w && $past(busy_w)) |-> $stable(len_q));

   // R9: an out-of-range length never launches a frame
   p_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_w && (frame_len == '0 || frame_len > LW'(MAX_LEN))) |=> !busy_w);

   // R10: line rests high while idle
   p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_w |-> sym_out_q);

endmodule

// File: tb/tbr_framer_tb.sv
module tbr_framer_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [5:0] frame_len = '0;
   logic       start = 1'b0;
   logic       bit_en = 1'b0;
   logic       sym_out, sym_valid, busy;

   always #4 clk = ~clk;

   tbr_framer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_len(frame_len), .start(start),
      .bit_en(bit_en), .sym_out(sym_out), .sym_valid(sym_valid), .busy(busy)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bit-rate enable generator: high one cycle in every div
   int div = 1;
   int en_cnt = 0;
   always @(negedge clk) begin
      bit_en <= (en_cnt == 0);
      en_cnt <= (en_cnt + 1 >= div) ? 0 : en_cnt + 1;
   end

   // symbol capture
   logic got_bits [0:4095];
   logic got_busy [0:4095];
   int   got_n = 0;
   int   rate_viol = 0;
   always @(negedge clk) begin
      if (sym_valid) begin
         if (got_n < 4096) begin
            got_bits[got_n] <= sym_out;
            got_busy[got_n] <= busy;
         end
         got_n <= got_n + 1;
         if (!bit_en) rate_viol <= rate_viol + 1;
      end
   end

   logic [7:0] tb_bytes [0:31];
   logic       exp_bits [0:511];
   int         exp_n;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic build_exp(input int n);
      int k = 0;
      for (int i = 0; i < 20; i++) begin exp_bits[k] = 1'b1; k++; end
      for (int i = 0; i < 10; i++) begin exp_bits[k] = 1'b0; k++; end
      for (int i = 0; i < 2; i++)  begin exp_bits[k] = 1'b1; k++; end
      for (int b = 0; b < n; b++) begin
         exp_bits[k] = 1'b0; k++;
         for (int j = 0; j < 8; j++) begin exp_bits[k] = tb_bytes[b][j]; k++; end
         exp_bits[k] = 1'b1; k++;
      end
      for (int i = 0; i < 10; i++) begin exp_bits[k] = 1'b0; k++; end
      for (int i = 0; i < 2; i++)  begin exp_bits[k] = 1'b1; k++; end
      exp_n = k;
   endtask

   // mismatch count in [lo, hi) of the captured frame starting at base
   function automatic int region_err(input int base, input int lo, input int hi);
      int e = 0;
      for (int i = lo; i < hi; i++) begin
         if (got_bits[base + i] !== exp_bits[i]) e++;
      end
      return e;
   endfunction

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && sym_valid == 1'b0 && sym_out == 1'b1, "R1 reset outputs",
          {busy, sym_valid, sym_out}, 3'b001);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && sym_out == 1'b1, "R1 after release", {busy, sym_out}, 2'b01);
   endtask

   task automatic t_frame(input string tag, input int n, input int d, input bit mid);
      int base, cyc, nd, b;
      div = d;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = 5'(i); wr_data = tb_bytes[i];
      end
      @(negedge clk);
      wr_en = 1'b0;
      build_exp(n);
      frame_len = 6'(n);
      start = 1'b1;
      base = got_n;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, {tag, " R2 busy after start"}, busy, 1);
      cyc = 0;
      while (busy && cyc < (exp_n + 4) * d + 20) begin
         @(negedge clk);
         cyc++;
         if (mid && cyc == 40) begin start = 1'b1; frame_len = 6'd3; end
         if (mid && cyc == 41) start = 1'b0;
      end
      repeat (3) @(negedge clk);
      nd = got_n - base;
      chk(nd == exp_n, {tag, " R5 symbol count"}, nd, exp_n);
      if (nd == exp_n) begin
         b = exp_n - 12;
         chk(region_err(base, 0, 20) == 0, {tag, " R2 preamble errors"}, region_err(base, 0, 20), 0);
         chk(region_err(base, 20, 32) == 0, {tag, " R3 start marker errors"}, region_err(base, 20, 32), 0);
         chk(region_err(base, 32, b) == 0, {tag, " R4 payload errors"}, region_err(base, 32, b), 0);
         chk(region_err(base, b, exp_n) == 0, {tag, " R5 end marker errors"}, region_err(base, b, exp_n), 0);
         chk(got_busy[base + exp_n - 1] == 1'b0 && got_busy[base + exp_n - 2] == 1'b1,
             {tag, " R7 busy at last two symbols"},
             {got_busy[base + exp_n - 2], got_busy[base + exp_n - 1]}, 2'b10);
         if (mid) chk(region_err(base, 0, exp_n) == 0, {tag, " R8 frame unchanged by restart"},
                      region_err(base, 0, exp_n), 0);
      end
      chk(sym_out == 1'b1 && busy == 1'b0, {tag, " R10 idle high"}, {busy, sym_out}, 2'b01);
      chk(rate_viol == 0, {tag, " R6 symbols without enable"}, rate_viol, 0);
   endtask

   task automatic t_bad_len(input int len);
      int base;
      div = 1;
      @(negedge clk);
      frame_len = 6'(len);
      start = 1'b1;
      base = got_n;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b0, "R9 busy after bad length", busy, 0);
      repeat (4) @(negedge clk);
      chk(got_n == base && busy == 1'b0, "R9 no symbols for bad length", got_n - base, 0);
      chk(sym_out == 1'b1, "R10 idle high after reject", sym_out, 1);
   endtask

   initial begin
      t_reset();
      tb_bytes[0] = 8'hA5; tb_bytes[1] = 8'h3C; tb_bytes[2] = 8'h01;
      tb_bytes[3] = 8'h80; tb_bytes[4] = 8'hFF;
      t_frame("five bytes full rate", 5, 1, 1'b0);
      t_frame("five bytes div3 R6", 5, 3, 1'b0);
      tb_bytes[0] = 8'h6B;
      t_frame("R11 one byte", 1, 1, 1'b0);
      for (int i = 0; i < 32; i++) tb_bytes[i] = 8'((i * 37 + 11) & 8'hFF);
      t_frame("R11 max length", 32, 2, 1'b0);
      tb_bytes[0] = 8'h0F; tb_bytes[1] = 8'hE2; tb_bytes[2] = 8'h55;
      tb_bytes[3] = 8'h00; tb_bytes[4] = 8'hC3; tb_bytes[5] = 8'h7E;
      t_frame("R8 restart ignored", 6, 1, 1'b1);
      t_bad_len(0);
      t_bad_len(33);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule